// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This block connects a small processor datapath to a data memory that is one 32-bit word wide. The datapath gives a byte address, a 3-bit operation code and store data in a single cycle, with `req_vld` high. The unit removes the two low address bits to form the word address. It uses those bits and the access size to build a four-lane byte mask. It copies narrow store values into every lane and drives active-low memory-enable and write-enable strobes.

For loads, the memory must return the addressed word exactly one clock after the strobe, with no output register of its own. The unit delays the operation code and the low address bits through that cycle. It then cuts the selected byte or halfword out of the returned word, zero-extends it, and holds it in its own result register. `rsp_vld` pulses for one cycle when that register takes a new value.

Data flows in one direction only, so there is no back-pressure. A request is taken in every cycle that `req_vld` is high, and the consumer must take `rsp_vld` in the cycle it is raised. Lanes are big-endian: mask bit 3 and data bits 31:24 belong to byte offset 0.

Top module: `lane_lsu`

## Requirements
- R1: During an access, `mem_addr` equals `req_addr` without its two least significant bits.
- R2: Mask bit 3 covers data bits 31:24 and mask bit 0 covers bits 7:0. A word access sets mask 1111. A halfword access sets 1100 when address bit 1 is 0 and 0011 when it is 1; address bit 0 is ignored. A byte access sets 1000 shifted right by the two low address bits.
- R3: `mem_en_n` is 0 only in a cycle where `req_vld` is 1 with a defined opcode; otherwise it is 1.
- R4: Opcodes: 000 store word, 001 store halfword, 010 store byte, 100 load word, 101 load halfword unsigned, 110 load byte unsigned. `mem_we_n` is 0 for a store access and 1 for a load or when idle.
- R5: Store data is copied to every lane: a byte store drives its low 8 bits four times and a halfword store drives its low 16 bits twice. A word store drives the word unchanged.
- R6: A load issued in cycle N samples `mem_rdata` in cycle N+1. `rsp_vld` is 1 and `rsp_data` holds the result in cycle N+2.
- R7: A halfword load returns data bits 31:16 when address bit 1 is 0 and bits 15:0 when it is 1, zero-extended to 32 bits.
- R8: A byte load returns the lane chosen by the two low address bits (offset 0 is bits 31:24), zero-extended to 32 bits.
- R9: Loads issued in consecutive cycles are each sliced with their own opcode and offset.
- R10: Opcodes 011 and 111 start no access and produce no response.
- R11: After reset, `rsp_vld` is 0, `rsp_data` is 0 and both strobes are 1.
- R12: Stores raise no `rsp_vld`, and `rsp_data` changes only in a cycle where `rsp_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_vld | output | 1 | Load result updated this cycle |
| rsp_data | output | 32 | Registered, zero-extended load result |
| mem_en_n | output | 1 | Memory enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_mask | output | 4 | Byte-lane enables, 1 = lane active |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Word read from memory, one cycle after request |

## Verification
A store can be issued in the cycle after a load. Its strobes, mask and copied data then go to memory in the same cycle that the unit slices the word returned for that load. The bench sets this up as a word load followed at once by a byte store to the same word. It checks the store's strobes and lanes during the overlap cycle. It then checks that the response carries the word as it was before the store, and a later reload shows that only the masked byte changed.

// File: rtl/lane_lsu_pkg.sv
package lane_lsu_pkg;
  localparam int DATA_W = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [2:0] {
    OP_SW  = 3'b000,
    OP_SH  = 3'b001,
    OP_SB  = 3'b010,
    OP_LW  = 3'b100,
    OP_LHU = 3'b101,
    OP_LBU = 3'b110
  } lsu_op_e;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic             vld;
    acc_size_e        size;
    logic [OFF_W-1:0] off;
  } load_tag_t;
endpackage

// File: rtl/lane_lsu_decode.sv
module lane_lsu_decode
  import lane_lsu_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              req_vld,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              access,
  output logic              is_store,
  output acc_size_e         size,
  output logic [OFF_W-1:0]  off,
  output logic [ADDR_W-3:0] word_addr,
  output logic [LANES-1:0]  mask
);
  acc_size_e sz_raw;
  logic      st_raw;

  always_comb begin
    st_raw = 1'b0;
    unique case (req_op)
      OP_SW:   begin sz_raw = SZ_WORD; st_raw = 1'b1; end
      OP_SH:   begin sz_raw = SZ_HALF; st_raw = 1'b1; end
      OP_SB:   begin sz_raw = SZ_BYTE; st_raw = 1'b1; end
      OP_LW:   sz_raw = SZ_WORD;
      OP_LHU:  sz_raw = SZ_HALF;
      OP_LBU:  sz_raw = SZ_BYTE;
      default: sz_raw = SZ_NONE;
    endcase
  end

  assign access    = req_vld && (sz_raw != SZ_NONE);
  assign is_store  = st_raw;
  assign size      = sz_raw;
  assign off       = req_addr[OFF_W-1:0];
  assign word_addr = req_addr[ADDR_W-1:OFF_W];

  // lane g counted from the most significant byte
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [OFF_W-1:0] LN = OFF_W'(g);
    logic hit;
    always_comb begin
      unique case (sz_raw)
        SZ_WORD: hit = 1'b1;
        SZ_HALF: hit = (off[OFF_W-1] == LN[OFF_W-1]);
        SZ_BYTE: hit = (off == LN);
        default: hit = 1'b0;
      endcase
    end
    assign mask[LANES-1-g] = access && hit;
  end
endmodule

// File: rtl/lane_lsu_store_place.sv
module lane_lsu_store_place
  import lane_lsu_pkg::*;
(
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [DATA_W-1:0] wdata_out
);
  localparam int HALF_W = DATA_W / 2;
  logic [DATA_W-1:0] rep_byte, rep_half;

  for (genvar g = 0; g < LANES; g++) begin : g_b
    assign rep_byte[g*LANE_W +: LANE_W] = wdata_in[LANE_W-1:0];
  end
  for (genvar h = 0; h < 2; h++) begin : g_h
    assign rep_half[h*HALF_W +: HALF_W] = wdata_in[HALF_W-1:0];
  end

  always_comb begin
    unique case (size)
      SZ_HALF: wdata_out = rep_half;
      SZ_BYTE: wdata_out = rep_byte;
      default: wdata_out = wdata_in;
    endcase
  end
endmodule

// File: rtl/lane_lsu_load_align.sv
module lane_lsu_load_align
  import lane_lsu_pkg::*;
(
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] value
);
  localparam int HALF_W = DATA_W / 2;
  logic [LANE_W-1:0] lane [LANES];
  logic [HALF_W-1:0] half_v;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word[DATA_W-1-g*LANE_W -: LANE_W];
  end

  assign half_v = off[OFF_W-1] ? word[HALF_W-1:0] : word[DATA_W-1:HALF_W];

  always_comb begin
    unique case (size)
      SZ_HALF: value = {{(DATA_W-HALF_W){1'b0}}, half_v};
      SZ_BYTE: value = {{(DATA_W-LANE_W){1'b0}}, lane[off]};
      default: value = word;
    endcase
  end
endmodule

// File: rtl/lane_lsu.sv
module lane_lsu
  import lane_lsu_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_vld,
  output logic [31:0]       rsp_data,
  output logic              mem_en_n,
  output logic              mem_we_n,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [3:0]        mem_mask,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  logic             access, is_store;
  acc_size_e        size;
  logic [OFF_W-1:0] off;
  load_tag_t        tag_q;
  logic [DATA_W-1:0] aligned;

  lane_lsu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_vld   (req_vld),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .access    (access),
    .is_store  (is_store),
    .size      (size),
    .off       (off),
    .word_addr (mem_addr),
    .mask      (mem_mask)
  );

  lane_lsu_store_place u_st (
    .size      (size),
    .wdata_in  (req_wdata),
    .wdata_out (mem_wdata)
  );

  assign mem_en_n = !access;
  assign mem_we_n = !(access && is_store);

  // tag travels alongside the memory's read cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '{vld: 1'b0, size: SZ_NONE, off: '0};
    end else begin
      tag_q.vld  <= access && !is_store;
      tag_q.size <= size;
      tag_q.off  <= off;
    end
  end

  lane_lsu_load_align u_ld (
    .size  (tag_q.size),
    .off   (tag_q.off),
    .word  (mem_rdata),
    .value (aligned)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld  <= 1'b0;
      rsp_data <= '0;
    end else begin
      rsp_vld <= tag_q.vld;
      if (tag_q.vld) rsp_data <= aligned;
    end
  end
endmodule

// File: rtl/lane_lsu_chk.sv
module lane_lsu_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_vld,
  input logic [31:0]       rsp_data,
  input logic              mem_en_n,
  input logic              mem_we_n,
  input logic [ADDR_W-3:0] mem_addr,
  input logic [3:0]        mem_mask
);
  p_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en_n |-> mem_addr == req_addr[ADDR_W-1:2]);

  p_mask_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en_n |-> (mem_mask == 4'b1111 || mem_mask == 4'b1100 || mem_mask == 4'b0011
                   || $countones(mem_mask) == 1));

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |-> mem_en_n && mem_we_n);

  p_load_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en_n && req_op[2]) |-> mem_we_n);

  p_rsp_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> $past(!mem_en_n && mem_we_n, 2));

  p_half_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && $past(req_vld && req_op == 3'b101, 2)) |-> rsp_data[31:16] == 16'h0);

  p_byte_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && $past(req_vld && req_op == 3'b110, 2)) |-> rsp_data[31:8] == 24'h0);

  p_undef_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_op[1:0] == 2'b11) |-> mem_en_n);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> $stable(rsp_data));
endmodule

bind lane_lsu lane_lsu_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_lane_lsu.sv
`timescale 1ns/1ps
module sim_lane_lsu;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_vld = 1'b0;
  logic [2:0]    req_op = 3'b000;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_vld, mem_en_n, mem_we_n;
  logic [31:0]   rsp_data, mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic [AW-3:0] mem_addr;
  logic [3:0]    mem_mask;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] mem [16];

  always #2 clk = ~clk;

  lane_lsu #(.ADDR_W(AW)) u0 (.*);

  // bench memory: one cycle read latency, lane-masked writes
  always @(posedge clk) begin
    if (!mem_en_n) begin
      if (!mem_we_n) begin
        for (int i = 0; i < 4; i++)
          if (mem_mask[3-i]) mem[mem_addr[3:0]][31-8*i -: 8] <= mem_wdata[31-8*i -: 8];
      end else begin
        mem_rdata <= mem[mem_addr[3:0]];
      end
    end
  end

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  ba;
    logic [31:0] wd;
    logic [3:0]  mk;
    logic [31:0] rs;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{3'b100, 8'h00, 32'h0,        4'b1111, 32'h11223344},
    '{3'b100, 8'h04, 32'h0,        4'b1111, 32'hA1B2C3D4},
    '{3'b110, 8'h01, 32'h0,        4'b0100, 32'h00000022},
    '{3'b110, 8'h07, 32'h0,        4'b0001, 32'h000000D4},
    '{3'b101, 8'h02, 32'h0,        4'b0011, 32'h00003344},
    '{3'b101, 8'h05, 32'h0,        4'b1100, 32'h0000A1B2},
    '{3'b010, 8'h0A, 32'h123456EE, 4'b0010, 32'h0000A1B2},
    '{3'b001, 8'h08, 32'h7777BEEF, 4'b1100, 32'h0000A1B2},
    '{3'b100, 8'h08, 32'h0,        4'b1111, 32'hBEEFEE88},
    '{3'b000, 8'h0C, 32'hCAFEF00D, 4'b1111, 32'hBEEFEE88},
    '{3'b110, 8'h0C, 32'h0,        4'b1000, 32'h000000CA},
    '{3'b100, 8'h0F, 32'h0,        4'b1111, 32'hCAFEF00D}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [2:0] op, logic [7:0] ba, logic [31:0] wd);
    req_vld = v; req_op = op; req_addr = {2'b00, ba}; req_wdata = wd;
  endtask

  function automatic logic [31:0] place(logic [2:0] op, logic [31:0] wd);
    case (op[1:0])
      2'b01:   return {2{wd[15:0]}};
      2'b10:   return {4{wd[7:0]}};
      default: return wd;
    endcase
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
    summary();
  end

  initial begin
    mem[0] = 32'h11223344; mem[1] = 32'hA1B2C3D4; mem[2] = 32'h55667788;
    mem[3] = 32'h0;        mem[4] = 32'h0F1E2D3C;
    for (int i = 5; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R11 reset state
    chk("R11 rsp_vld", {31'b0, rsp_vld}, 32'd0);
    chk("R11 rsp_data", rsp_data, 32'h0);
    chk("R11 mem_en_n", {31'b0, mem_en_n}, 32'd1);
    chk("R11 mem_we_n", {31'b0, mem_we_n}, 32'd1);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(1'b1, VEC[v].op, VEC[v].ba, VEC[v].wd);
      #1;
      chk("R1 word address", {24'b0, mem_addr}, {26'b0, VEC[v].ba[7:2]});
      chk("R2 lane mask", {28'b0, mem_mask}, {28'b0, VEC[v].mk});
      chk("R3 enable low", {31'b0, mem_en_n}, 32'd0);
      chk("R4 write enable", {31'b0, mem_we_n}, {31'b0, VEC[v].op[2]});
      if (!VEC[v].op[2]) chk("R5 store lanes", mem_wdata, place(VEC[v].op, VEC[v].wd));
      @(negedge clk);
      drive(1'b0, 3'b100, 8'h00, 32'h0);
      @(negedge clk); #1;
      chk("R6/R12 rsp_vld", {31'b0, rsp_vld}, {31'b0, VEC[v].op[2]});
      chk("R6/R7/R8 result", rsp_data, VEC[v].rs);
    end

    // R3: load opcode with req_vld low starts nothing
    @(negedge clk); drive(1'b0, 3'b100, 8'h04, 32'h0); #1;
    chk("R3 idle with load op", {31'b0, mem_en_n}, 32'd1);

    // R10: undefined opcodes
    @(negedge clk); drive(1'b1, 3'b011, 8'h00, 32'hFFFFFFFF); #1;
    chk("R10 op 011 no enable", {31'b0, mem_en_n}, 32'd1);
    chk("R10 op 011 no write", {31'b0, mem_we_n}, 32'd1);
    @(negedge clk); drive(1'b1, 3'b111, 8'h04, 32'h0); #1;
    chk("R10 op 111 no enable", {31'b0, mem_en_n}, 32'd1);
    @(negedge clk); drive(1'b0, 3'b000, 8'h00, 32'h0); #1;
    chk("R10 no response", {31'b0, rsp_vld}, 32'd0);
    @(negedge clk); #1;
    chk("R10 no response", {31'b0, rsp_vld}, 32'd0);
    chk("R10 result held", rsp_data, 32'hCAFEF00D);
    chk("R10 memory intact", mem[0], 32'h11223344);

    // R9: back-to-back loads of different sizes
    @(negedge clk); drive(1'b1, 3'b110, 8'h03, 32'h0);
    @(negedge clk); drive(1'b1, 3'b101, 8'h06, 32'h0);
    @(negedge clk); drive(1'b1, 3'b100, 8'h08, 32'h0); #1;
    chk("R9 first byte load", rsp_data, 32'h00000044);
    @(negedge clk); drive(1'b0, 3'b000, 8'h00, 32'h0); #1;
    chk("R9 second halfword load", rsp_data, 32'h0000C3D4);
    chk("R9 rsp_vld held high", {31'b0, rsp_vld}, 32'd1);
    @(negedge clk); #1;
    chk("R9 third word load", rsp_data, 32'hBEEFEE88);

    // overlap: store issued while the previous load's word is sliced
    @(negedge clk); drive(1'b1, 3'b100, 8'h10, 32'h0);
    @(negedge clk); drive(1'b1, 3'b010, 8'h13, 32'h0000005A); #1;
    chk("R4 overlap store write", {31'b0, mem_we_n}, 32'd0);
    chk("R2 overlap store mask", {28'b0, mem_mask}, 32'h1);
    chk("R5 overlap store lanes", mem_wdata, 32'h5A5A5A5A);
    @(negedge clk); drive(1'b0, 3'b000, 8'h00, 32'h0); #1;
    chk("R6 overlap load result", rsp_data, 32'h0F1E2D3C);
    chk("R6 overlap rsp_vld", {31'b0, rsp_vld}, 32'd1);
    @(negedge clk); #1;
    chk("R12 store gives no rsp", {31'b0, rsp_vld}, 32'd0);
    @(negedge clk); drive(1'b1, 3'b100, 8'h10, 32'h0);
    @(negedge clk); drive(1'b0, 3'b000, 8'h00, 32'h0);
    @(negedge clk); #1;
    chk("R2 only masked lane written", rsp_data, 32'h0F1E2D5A);

    // R7: halfword load with bit 0 set in the upper half
    @(negedge clk); drive(1'b1, 3'b101, 8'h0F, 32'h0);
    @(negedge clk); drive(1'b0, 3'b000, 8'h00, 32'h0);
    @(negedge clk); #1;
    chk("R7 halfword offset 3", rsp_data, 32'h0000F00D);

    summary();
  end
endmodule